// File: doc/BRIEF.md
# Receive Idle-Timeout Detector

This block sits beside a receive FIFO and tells the interrupt logic when characters have been left unread for too long. While the FIFO holds data and no push or pop has touched it, the block counts per-bit baud ticks. When the count reaches four character times, it raises a level timeout flag. The length of a character comes from a configured frame length in bits: start, data, parity and stop bits together. Any push or pop clears the flag and starts the window again. An empty FIFO keeps the window at zero.

The block also produces the companion data-available flag. It compares the FIFO occupancy with a threshold that a 2-bit selector picks, and it registers the result. The block has no data path, so every pin is a plain control or status signal and there is no valid/ready handshake. The two flags are meant to go straight to a priority encoder that identifies the interrupt source.

Top module: `rx_char_timeout`

## Requirements
- R1: While `fifo_nonempty_i` is low, `timeout_o` stays low, whatever baud ticks arrive.
- R2: With the FIFO non-empty and idle, `timeout_o` rises on the clock edge that samples the 4×L-th `baud_tick_i` since the last activity, where L is `frame_bits_i`. It is low after the (4×L−1)-th tick.
- R3: Once `timeout_o` is high, further baud ticks and idle cycles keep it high until a push, a pop or an empty FIFO.
- R4: A cycle with `fifo_push_i` high drives `timeout_o` low after that edge and restarts the window, even if a tick arrives in the same cycle. A full 4×L ticks are then needed again.
- R5: A cycle with `fifo_pop_i` high drives `timeout_o` low after that edge and restarts the window. A full 4×L ticks are then needed again.
- R6: Clock cycles with `baud_tick_i` low do not advance the idle window.
- R7: `data_avail_o` goes high one edge after `fifo_level_i` is at or above the threshold chosen by `trig_sel_i`, using 2'b00→1, 2'b01→4, 2'b10→8, 2'b11→14 entries.
- R8: `data_avail_o` goes low one edge after `fifo_level_i` falls below the selected threshold.
- R9: The window length follows `frame_bits_i`. For example, with L=7 the flag rises on the 28th tick and not on the 27th.
- R10: When `fifo_nonempty_i` falls, `timeout_o` is low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fifo_nonempty_i | input | 1 | Receive FIFO holds at least one entry |
| fifo_push_i | input | 1 | FIFO write strobe |
| fifo_pop_i | input | 1 | FIFO read strobe |
| baud_tick_i | input | 1 | One-cycle pulse per bit time |
| frame_bits_i | input | 4 | Bits per character, including start and stop bits |
| fifo_level_i | input | 5 | Current FIFO occupancy |
| trig_sel_i | input | 2 | Threshold selector for data-available |
| timeout_o | output | 1 | Idle timeout flag (level) |
| data_avail_o | output | 1 | Occupancy at or above threshold (registered) |

## Verification
The assertions assume a few things about the inputs. `frame_bits_i` is non-zero, and it changes only while the FIFO is empty or the flag is low. Strobes and ticks are single-cycle synchronous pulses. The hold and no-rise checks tolerate a change of `frame_bits_i` in the cycle they examine. The stimulus meets these assumptions: it changes the frame length only between scenarios with the FIFO empty, and it changes the selector and level only at cycle boundaries, away from the sampling point.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  localparam int unsigned LEVEL_W = 5;

  function automatic logic [LEVEL_W-1:0] trig_threshold(input logic [1:0] sel);
    logic [LEVEL_W-1:0] thr;
    unique case (sel)
      2'b00:   thr = LEVEL_W'(1);
      2'b01:   thr = LEVEL_W'(4);
      2'b10:   thr = LEVEL_W'(8);
      default: thr = LEVEL_W'(14);
    endcase
    return thr;
  endfunction
endpackage

// File: rtl/rxto_window.sv
module rxto_window #(
  parameter int unsigned CHAR_W   = 4,
  parameter int unsigned WIN_LOG2 = 2,
  localparam int unsigned CNT_W   = CHAR_W + WIN_LOG2
) (
  input  logic [CHAR_W-1:0] frame_bits_i,
  output logic [CNT_W-1:0]  target_o
);
  // window = 2**WIN_LOG2 character times, in baud ticks
  assign target_o = {frame_bits_i, {WIN_LOG2{1'b0}}};
endmodule

// File: rtl/rxto_idle_cnt.sv
module rxto_idle_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nonempty_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             restart;

  assign restart = !nonempty_i || push_i || pop_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart)                     cnt_q <= '0;
    else if (tick_i && cnt_q < target_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign timeout_o = (target_i != '0) && (cnt_q >= target_i);

  assert_empty_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nonempty_i |=> !timeout_o);

  // covers R4 and R5
  assert_activity_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || pop_i) |=> !timeout_o);

  assert_saturate_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !restart) |=> (timeout_o || !$stable(target_i)));

  assert_no_tick_no_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !timeout_o) |=> (!timeout_o || !$stable(target_i)));
endmodule

// File: rtl/rxto_trig_cmp.sv
module rxto_trig_cmp
  import rxto_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [1:0]         sel_i,
  output logic               avail_o
);
  logic hit;
  assign hit = level_i >= trig_threshold(sel_i);

  generate
    if (REGISTERED) begin : g_reg
      logic avail_q;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) avail_q <= 1'b0;
        else         avail_q <= hit;
      end
      assign avail_o = avail_q;

      assert_lowest_thr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == 2'b00 && level_i != '0) |=> avail_o);

      assert_below_top_thr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == 2'b11 && level_i < LEVEL_W'(14)) |=> !avail_o);
    end else begin : g_comb
      assign avail_o = hit;
    end
  endgenerate
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout
  import rxto_pkg::*;
#(
  parameter int unsigned CHAR_W   = 4,
  parameter int unsigned WIN_LOG2 = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_nonempty_i,
  input  logic               fifo_push_i,
  input  logic               fifo_pop_i,
  input  logic               baud_tick_i,
  input  logic [CHAR_W-1:0]  frame_bits_i,
  input  logic [LEVEL_W-1:0] fifo_level_i,
  input  logic [1:0]         trig_sel_i,
  output logic               timeout_o,
  output logic               data_avail_o
);
  localparam int unsigned CNT_W = CHAR_W + WIN_LOG2;

  logic [CNT_W-1:0] target;

  rxto_window #(.CHAR_W(CHAR_W), .WIN_LOG2(WIN_LOG2)) u_window (
    .frame_bits_i (frame_bits_i),
    .target_o     (target)
  );

  rxto_idle_cnt #(.CNT_W(CNT_W)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nonempty_i (fifo_nonempty_i),
    .push_i     (fifo_push_i),
    .pop_i      (fifo_pop_i),
    .tick_i     (baud_tick_i),
    .target_i   (target),
    .timeout_o  (timeout_o)
  );

  rxto_trig_cmp #(.REGISTERED(1'b1)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (fifo_level_i),
    .sel_i   (trig_sel_i),
    .avail_o (data_avail_o)
  );

  assert_empty_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fifo_nonempty_i) |=> !timeout_o);
endmodule

// File: tb/rx_char_timeout_tb_top.sv
module rx_char_timeout_tb_top;
  typedef struct {
    logic  tmo;
    logic  av;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ne = 1'b0, psh = 1'b0, pp = 1'b0, tk = 1'b0;
  logic [3:0] bits = 4'd10;
  logic [4:0] level = 5'd1;
  logic [1:0] sel = 2'b01;
  logic       tmo, av;

  exp_t q[$];
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  rx_char_timeout dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_nonempty_i(ne), .fifo_push_i(psh),
    .fifo_pop_i(pp), .baud_tick_i(tk), .frame_bits_i(bits),
    .fifo_level_i(level), .trig_sel_i(sel), .timeout_o(tmo), .data_avail_o(av)
  );

  // driver: one cycle of stimulus, then queue the expected outputs
  task automatic cyc(input logic p, input logic o, input logic t,
                     input string req, input logic e_tmo, input logic e_av);
    exp_t e;
    @(negedge clk);
    psh = p; pp = o; tk = t;
    @(posedge clk);
    #1;
    e.tmo = e_tmo; e.av = e_av; e.req = req;
    q.push_back(e);
  endtask

  task automatic ticks(input int n, input string req, input logic e_tmo);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, req, e_tmo, 1'b0);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (tmo !== e.tmo || av !== e.av) begin
          bad++;
          $display("FAIL %s: tmo=%b av=%b expected tmo=%b av=%b", e.req, tmo, av, e.tmo, e.av);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, "R1", 0, 0);                 // reset state
    // frame of 10 bits: window 40 ticks
    ne = 1'b1;
    cyc(1, 0, 0, "R4", 0, 0);
    ticks(20, "R2", 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, "R6", 0, 0);
    ticks(19, "R2", 0);
    ticks(1, "R2", 1);
    ticks(5, "R3", 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, "R3", 1, 0);
    cyc(0, 1, 0, "R5", 0, 0);
    ticks(39, "R5", 0);
    ticks(1, "R5", 1);
    cyc(1, 0, 1, "R4", 0, 0);
    ticks(39, "R4", 0);
    ticks(1, "R4", 1);
    // drain to empty
    @(negedge clk); ne = 1'b0;
    cyc(0, 1, 0, "R10", 0, 0);
    ticks(60, "R1", 0);
    // 7-bit frame: window 28 ticks
    @(negedge clk); bits = 4'd7; ne = 1'b1;
    cyc(1, 0, 0, "R9", 0, 0);
    ticks(27, "R9", 0);
    ticks(1, "R9", 1);
    @(negedge clk); ne = 1'b0;
    cyc(0, 0, 0, "R10", 0, 0);
    // trigger thresholds
    @(negedge clk); sel = 2'b01; level = 5'd3;  cyc(0, 0, 0, "R7", 0, 0);
    @(negedge clk); level = 5'd4;               cyc(0, 0, 0, "R7", 0, 1);
    @(negedge clk); level = 5'd3;               cyc(0, 0, 0, "R8", 0, 0);
    @(negedge clk); sel = 2'b00; level = 5'd0;  cyc(0, 0, 0, "R8", 0, 0);
    @(negedge clk); level = 5'd1;               cyc(0, 0, 0, "R7", 0, 1);
    @(negedge clk); sel = 2'b10; level = 5'd7;  cyc(0, 0, 0, "R7", 0, 0);
    @(negedge clk); level = 5'd8;               cyc(0, 0, 0, "R7", 0, 1);
    @(negedge clk); sel = 2'b11; level = 5'd13; cyc(0, 0, 0, "R7", 0, 0);
    @(negedge clk); level = 5'd14;              cyc(0, 0, 0, "R7", 0, 1);
    @(negedge clk); level = 5'd15;              cyc(0, 0, 0, "R7", 0, 1);
    @(negedge clk); level = 5'd13;              cyc(0, 0, 0, "R8", 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule